// File: doc/BRIEF.md
# Context-Tagged Fully Associative Translation Buffer

This block keeps a handful of recently used page translations so that most memory references avoid a page-table fetch. Every stored translation is tagged with the context (process) number that owns it as well as its virtual page number. Because of this, translations belonging to different processes can stay in the buffer at the same time. A process switch rewrites only two registers, the active context number and that context's page-table base. The buffer is never flushed on a switch.

A lookup presents a virtual page number. One clock later the block returns either a hit with the physical page number, or a miss with the address of the page-table entry to fetch. That address is the active page-table base plus the page number. The walker, which is outside this block, writes the fetched translation back through the fill port. The fill goes to a free slot if there is one and otherwise replaces the least recently used slot. A store that hits marks its translation dirty and signals it, so that the page table's dirty flag can be brought up to date. An invalidate port removes one translation, given by context and page, when that page leaves memory.

Top module: `tlb_ctx_fa`

## Requirements
- R1: Synchronous active-high reset empties every slot, clears the response outputs and sets the active context and page-table base to zero.
- R2: A lookup with `lk_valid` high gives `rsp_valid` high on the next cycle. `rsp_hit` is high only if a valid slot holds both the active context and `lk_vpn`. On a hit, `rsp_ppn` returns that slot's page number.
- R3: On a miss, `rsp_walk_addr` equals the active page-table base plus the zero-extended page number, taken modulo 2^PTA_W.
- R4: A context write loads the new context number and base, which take effect from the following cycle. All stored translations are kept.
- R5: A fill is tagged with the active context. It writes the slot that already holds the same tag if one exists. Otherwise it writes the lowest-numbered empty slot. If there is no empty slot, it writes the least recently used slot.
- R6: A lookup hit and a fill each make the touched slot the most recently used. If a fill and a hit happen in the same cycle, only the fill updates the recency order.
- R7: A store hit (`lk_store` high) sets the slot's dirty flag. `rsp_dirty_set` is high only when that flag was clear before the store. Loads and store misses never raise it. A fill sets the flag from `fill_dirty`.
- R8: An invalidate removes the slot whose context and page equal `inv_ctx` and `inv_vpn`, whatever context is active. Slots that do not match are untouched.
- R9: A lookup sees the state from before any fill, invalidate or context write issued in the same cycle.
- R10: No two valid slots ever share the same context and page pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctx_wr | input | 1 | Load a new active context and page-table base |
| ctx_wr_id | input | CTX_W | New context number |
| ctx_wr_base | input | PTA_W | New page-table base address |
| lk_valid | input | 1 | Lookup request |
| lk_store | input | 1 | Lookup is for a store |
| lk_vpn | input | VPN_W | Virtual page number to translate |
| fill_valid | input | 1 | Write a translation returned by the walker |
| fill_vpn | input | VPN_W | Page number of the fill |
| fill_ppn | input | PPN_W | Physical page number of the fill |
| fill_dirty | input | 1 | Initial dirty flag of the fill |
| inv_valid | input | 1 | Remove one translation |
| inv_ctx | input | CTX_W | Context of the translation to remove |
| inv_vpn | input | VPN_W | Page number of the translation to remove |
| rsp_valid | output | 1 | Response to last cycle's lookup |
| rsp_hit | output | 1 | Lookup found a translation |
| rsp_ppn | output | PPN_W | Physical page number on a hit |
| rsp_dirty_set | output | 1 | A store hit turned the dirty flag on |
| rsp_walk_addr | output | PTA_W | Page-table entry address for the walker |

## Verification
The bench tests whether a stored translation survives a context switch and stays hidden from every other context. A design that flushed on a switch, or ignored the context field, would return a miss or the wrong page number. Replacement is tested in three situations: a full buffer, a freed slot, and a refill of an existing tag. An LRU error, ignoring free slots, or a duplicate slot would each evict a translation the bench then expects to hit. The bench also checks that the walk address wraps at its width and that the dirty report fires only on the first store to a clean page. Finally, it checks same-cycle fills and context writes, so that a lookup which saw the new state early would be caught.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  // width of a slot index; at least one bit
  function automatic int idx_w(input int n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 4,
  parameter int CTX_W = 4,
  parameter int VPN_W = 8,
  localparam int IW   = tlb_pkg::idx_w(N)
) (
  input  logic [N-1:0]            slot_v,
  input  logic [N-1:0][CTX_W-1:0] slot_ctx,
  input  logic [N-1:0][VPN_W-1:0] slot_vpn,
  input  logic [CTX_W-1:0]        key_ctx,
  input  logic [VPN_W-1:0]        key_vpn,
  output logic [N-1:0]            hit_vec,
  output logic                    hit_any,
  output logic [IW-1:0]           hit_idx
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = slot_v[i] && (slot_ctx[i] == key_ctx) && (slot_vpn[i] == key_vpn);
  end

  assign hit_any = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end
endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
  parameter int N   = 4,
  localparam int IW = tlb_pkg::idx_w(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim_idx
);
  logic [IW-1:0] age [N];
  logic [N-1:0]  oldest;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch_en) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx)        age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_old
    assign oldest[i] = (age[i] == IW'(N - 1));
  end

  always_comb begin
    victim_idx = '0;
    for (int i = 0; i < N; i++)
      if (oldest[i]) victim_idx = IW'(i);
  end

  // R6: ages stay a permutation, so exactly one slot is oldest
  a_r6_one_oldest: assert property (@(posedge clk) disable iff (rst)
    $countones(oldest) == 1);
  // R6: a touched slot becomes the youngest
  a_r6_touch_youngest: assert property (@(posedge clk) disable iff (rst)
    touch_en |=> age[$past(touch_idx)] == '0);
endmodule

// File: rtl/tlb_ctx_fa.sv
module tlb_ctx_fa #(
  parameter int N     = 4,
  parameter int CTX_W = 4,
  parameter int VPN_W = 8,
  parameter int PPN_W = 6,
  parameter int PTA_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctx_wr,
  input  logic [CTX_W-1:0] ctx_wr_id,
  input  logic [PTA_W-1:0] ctx_wr_base,
  input  logic             lk_valid,
  input  logic             lk_store,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_dirty,
  input  logic             inv_valid,
  input  logic [CTX_W-1:0] inv_ctx,
  input  logic [VPN_W-1:0] inv_vpn,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [PPN_W-1:0] rsp_ppn,
  output logic             rsp_dirty_set,
  output logic [PTA_W-1:0] rsp_walk_addr
);
  localparam int IW = tlb_pkg::idx_w(N);

  logic [N-1:0]            ent_v;
  logic [N-1:0]            ent_d;
  logic [N-1:0][CTX_W-1:0] ent_ctx;
  logic [N-1:0][VPN_W-1:0] ent_vpn;
  logic [PPN_W-1:0]        ent_ppn [N];

  logic [CTX_W-1:0] cur_ctx;
  logic [PTA_W-1:0] cur_base;

  logic [N-1:0]  lk_vec, fd_vec, inv_vec;
  logic          lk_any, fd_any, inv_any;
  logic [IW-1:0] lk_idx, fd_idx, inv_idx;
  logic          free_any;
  logic [IW-1:0] free_idx, victim_idx, fill_idx, touch_idx;
  logic          lk_hit, touch_en;

  tlb_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_lk_match (
    .slot_v(ent_v), .slot_ctx(ent_ctx), .slot_vpn(ent_vpn),
    .key_ctx(cur_ctx), .key_vpn(lk_vpn),
    .hit_vec(lk_vec), .hit_any(lk_any), .hit_idx(lk_idx));

  tlb_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_fill_match (
    .slot_v(ent_v), .slot_ctx(ent_ctx), .slot_vpn(ent_vpn),
    .key_ctx(cur_ctx), .key_vpn(fill_vpn),
    .hit_vec(fd_vec), .hit_any(fd_any), .hit_idx(fd_idx));

  tlb_match #(.N(N), .CTX_W(CTX_W), .VPN_W(VPN_W)) u_inv_match (
    .slot_v(ent_v), .slot_ctx(ent_ctx), .slot_vpn(ent_vpn),
    .key_ctx(inv_ctx), .key_vpn(inv_vpn),
    .hit_vec(inv_vec), .hit_any(inv_any), .hit_idx(inv_idx));

  // lowest-numbered empty slot
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!ent_v[i]) begin
        free_any = 1'b1;
        free_idx = IW'(i);
      end
    end
  end

  assign fill_idx  = fd_any ? fd_idx : (free_any ? free_idx : victim_idx);
  assign lk_hit    = lk_valid && lk_any;
  assign touch_en  = fill_valid || lk_hit;
  assign touch_idx = fill_valid ? fill_idx : lk_idx;

  tlb_lru #(.N(N)) u_lru (
    .clk(clk), .rst(rst),
    .touch_en(touch_en), .touch_idx(touch_idx),
    .victim_idx(victim_idx));

  // control state: valid, dirty, context registers, responses
  always_ff @(posedge clk) begin
    if (rst) begin
      ent_v         <= '0;
      ent_d         <= '0;
      cur_ctx       <= '0;
      cur_base      <= '0;
      rsp_valid     <= 1'b0;
      rsp_hit       <= 1'b0;
      rsp_ppn       <= '0;
      rsp_dirty_set <= 1'b0;
      rsp_walk_addr <= '0;
    end else begin
      if (ctx_wr) begin
        cur_ctx  <= ctx_wr_id;
        cur_base <= ctx_wr_base;
      end
      if (inv_valid && inv_any)
        ent_v[inv_idx] <= 1'b0;
      if (lk_hit && lk_store)
        ent_d[lk_idx] <= 1'b1;
      if (fill_valid) begin
        ent_v[fill_idx] <= 1'b1;
        ent_d[fill_idx] <= fill_dirty;
      end
      rsp_valid     <= lk_valid;
      rsp_hit       <= lk_hit;
      rsp_ppn       <= lk_hit ? ent_ppn[lk_idx] : '0;
      rsp_dirty_set <= lk_hit && lk_store && !ent_d[lk_idx];
      rsp_walk_addr <= cur_base + PTA_W'(lk_vpn);
    end
  end

  // tag and payload storage, written only by fills
  always_ff @(posedge clk) begin
    if (fill_valid) begin
      ent_ctx[fill_idx] <= cur_ctx;
      ent_vpn[fill_idx] <= fill_vpn;
      ent_ppn[fill_idx] <= fill_ppn;
    end
  end

  // R10: a tag is never held twice
  a_r10_single_match: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lk_vec));
  // R2: one response per request, one cycle later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> !rsp_valid);
  // R4: a context switch alone keeps every slot
  a_r4_switch_keeps: assert property (@(posedge clk) disable iff (rst)
    (ctx_wr && !fill_valid && !inv_valid) |=> ent_v == $past(ent_v));
  // R5: the filled slot is valid afterwards
  a_r5_fill_valid: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> ent_v[$past(fill_idx)]);
  // R8: an invalidate without a fill empties the matching slot
  a_r8_inv_clears: assert property (@(posedge clk) disable iff (rst)
    (inv_valid && !fill_valid) |=> (ent_v & $past(inv_vec)) == '0);
  // R7: the dirty report comes only with a hit
  a_r7_dirty_on_hit: assert property (@(posedge clk) disable iff (rst)
    rsp_dirty_set |-> rsp_hit);
endmodule

// File: tb/tb_tlb_ctx_fa.sv
module tb_tlb_ctx_fa;
  localparam int CLK_PERIOD = 10;
  localparam int CTX_W = 4, VPN_W = 8, PPN_W = 6, PTA_W = 12;

  // vector: op[40:38] ctx[37:34] vpn[33:26] data[25:14] exp_hit[13] exp_word[12:1] exp_flag[0]
  // op: 0 context write (data = base), 1 fill (data = ppn, flag = fill dirty),
  //     2 load, 3 store, 4 invalidate (ctx, vpn)
  localparam int NV = 44;
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 4'd1, 8'h00, 12'h100, 1'b0, 12'h000, 1'b0}, // ctx 1
    {3'd2, 4'd0, 8'h12, 12'h000, 1'b0, 12'h112, 1'b0}, // R3 miss
    {3'd1, 4'd0, 8'h12, 12'h005, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h12, 12'h000, 1'b1, 12'h005, 1'b0}, // R2 hit
    {3'd0, 4'd2, 8'h00, 12'h200, 1'b0, 12'h000, 1'b0}, // ctx 2
    {3'd2, 4'd0, 8'h12, 12'h000, 1'b0, 12'h212, 1'b0}, // R2 other context misses
    {3'd1, 4'd0, 8'h12, 12'h009, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h12, 12'h000, 1'b1, 12'h009, 1'b0},
    {3'd0, 4'd1, 8'h00, 12'h100, 1'b0, 12'h000, 1'b0}, // back to ctx 1
    {3'd2, 4'd0, 8'h12, 12'h000, 1'b1, 12'h005, 1'b0}, // R4 no flush
    {3'd3, 4'd0, 8'h12, 12'h000, 1'b1, 12'h005, 1'b1}, // R7 first store
    {3'd3, 4'd0, 8'h12, 12'h000, 1'b1, 12'h005, 1'b0}, // R7 already dirty
    {3'd1, 4'd0, 8'h20, 12'h00A, 1'b0, 12'h000, 1'b0},
    {3'd1, 4'd0, 8'h21, 12'h00B, 1'b0, 12'h000, 1'b0},
    {3'd1, 4'd0, 8'h22, 12'h00C, 1'b0, 12'h000, 1'b0}, // R5 evicts ctx2 entry
    {3'd0, 4'd2, 8'h00, 12'h200, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h12, 12'h000, 1'b0, 12'h212, 1'b0}, // R6 LRU gone
    {3'd0, 4'd1, 8'h00, 12'h100, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h20, 12'h000, 1'b1, 12'h00A, 1'b0}, // R6 touch
    {3'd1, 4'd0, 8'h23, 12'h00D, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h12, 12'h000, 1'b0, 12'h112, 1'b0}, // R6 evicted
    {3'd2, 4'd0, 8'h21, 12'h000, 1'b1, 12'h00B, 1'b0},
    {3'd4, 4'd1, 8'h21, 12'h000, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h21, 12'h000, 1'b0, 12'h121, 1'b0}, // R8 removed
    {3'd1, 4'd0, 8'h30, 12'h00E, 1'b0, 12'h000, 1'b0}, // R5 into free slot
    {3'd2, 4'd0, 8'h20, 12'h000, 1'b1, 12'h00A, 1'b0},
    {3'd2, 4'd0, 8'h22, 12'h000, 1'b1, 12'h00C, 1'b0},
    {3'd2, 4'd0, 8'h23, 12'h000, 1'b1, 12'h00D, 1'b0},
    {3'd2, 4'd0, 8'h30, 12'h000, 1'b1, 12'h00E, 1'b0},
    {3'd4, 4'd5, 8'h20, 12'h000, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h20, 12'h000, 1'b1, 12'h00A, 1'b0}, // R8 other ctx untouched
    {3'd4, 4'd1, 8'h30, 12'h000, 1'b0, 12'h000, 1'b0},
    {3'd1, 4'd0, 8'h31, 12'h007, 1'b0, 12'h000, 1'b1}, // fill dirty
    {3'd3, 4'd0, 8'h31, 12'h000, 1'b1, 12'h007, 1'b0}, // R7 dirty from fill
    {3'd3, 4'd0, 8'h22, 12'h000, 1'b1, 12'h00C, 1'b1},
    {3'd0, 4'd3, 8'h00, 12'hFF0, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h20, 12'h000, 1'b0, 12'h010, 1'b0}, // R3 wrap
    {3'd3, 4'd0, 8'h40, 12'h000, 1'b0, 12'h030, 1'b0}, // R7 store miss
    {3'd1, 4'd0, 8'h40, 12'h015, 1'b0, 12'h000, 1'b0},
    {3'd1, 4'd0, 8'h40, 12'h016, 1'b0, 12'h000, 1'b0}, // R5 refill same tag
    {3'd2, 4'd0, 8'h40, 12'h000, 1'b1, 12'h016, 1'b0},
    {3'd0, 4'd1, 8'h00, 12'h100, 1'b0, 12'h000, 1'b0},
    {3'd2, 4'd0, 8'h20, 12'h000, 1'b1, 12'h00A, 1'b0}, // R5 no duplicate eviction
    {3'd2, 4'd0, 8'h23, 12'h000, 1'b0, 12'h123, 1'b0}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic             ctx_wr = 0, lk_valid = 0, lk_store = 0, fill_valid = 0, fill_dirty = 0, inv_valid = 0;
  logic [CTX_W-1:0] ctx_wr_id = '0, inv_ctx = '0;
  logic [PTA_W-1:0] ctx_wr_base = '0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0, inv_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic             rsp_valid, rsp_hit, rsp_dirty_set;
  logic [PPN_W-1:0] rsp_ppn;
  logic [PTA_W-1:0] rsp_walk_addr;

  int n_chk = 0, n_bad = 0;
  logic done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tlb_ctx_fa #(.N(4), .CTX_W(CTX_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .PTA_W(PTA_W)) dut (
    .clk(clk), .rst(rst),
    .ctx_wr(ctx_wr), .ctx_wr_id(ctx_wr_id), .ctx_wr_base(ctx_wr_base),
    .lk_valid(lk_valid), .lk_store(lk_store), .lk_vpn(lk_vpn),
    .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_dirty(fill_dirty),
    .inv_valid(inv_valid), .inv_ctx(inv_ctx), .inv_vpn(inv_vpn),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_ppn(rsp_ppn),
    .rsp_dirty_set(rsp_dirty_set), .rsp_walk_addr(rsp_walk_addr));

  task automatic idle_inputs();
    ctx_wr = 0; lk_valid = 0; lk_store = 0; fill_valid = 0; fill_dirty = 0; inv_valid = 0;
  endtask

  // compare a response sampled at a falling edge
  task automatic check_rsp(input string req, input logic eh, input logic [11:0] ew, input logic es);
    logic ok;
    n_chk++;
    ok = rsp_valid && (rsp_hit == eh) && (rsp_dirty_set == es) &&
         (eh ? (rsp_ppn == ew[PPN_W-1:0]) : (rsp_walk_addr == ew));
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: valid=%0b hit=%0b ppn=%h walk=%h dset=%0b, expected hit=%0b word=%h dset=%0b",
               req, rsp_valid, rsp_hit, rsp_ppn, rsp_walk_addr, rsp_dirty_set, eh, ew, es);
    end
  endtask

  task automatic drive_vec(input logic [40:0] v);
    idle_inputs();
    case (v[40:38])
      3'd0: begin ctx_wr = 1; ctx_wr_id = v[37:34]; ctx_wr_base = v[25:14]; end
      3'd1: begin fill_valid = 1; fill_vpn = v[33:26]; fill_ppn = v[PPN_W+13:14]; fill_dirty = v[0]; end
      3'd2: begin lk_valid = 1; lk_vpn = v[33:26]; end
      3'd3: begin lk_valid = 1; lk_store = 1; lk_vpn = v[33:26]; end
      default: begin inv_valid = 1; inv_ctx = v[37:34]; inv_vpn = v[33:26]; end
    endcase
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: outputs quiet after reset
    n_chk++;
    if (rsp_valid || rsp_hit || rsp_dirty_set) begin
      n_bad++;
      $display("FAIL R1: valid=%0b hit=%0b dset=%0b expected 0 0 0", rsp_valid, rsp_hit, rsp_dirty_set);
    end

    for (int k = 0; k < NV; k++) begin
      drive_vec(VEC[k]);
      @(negedge clk);
      idle_inputs();
      if (VEC[k][40:38] == 3'd2 || VEC[k][40:38] == 3'd3)
        check_rsp(VEC[k][40:38] == 3'd3 ? "R7 store" : (VEC[k][13] ? "R2 hit" : "R3 miss"),
                  VEC[k][13], VEC[k][12:1], VEC[k][0]);
    end

    // R1: mid-run reset empties slots and zeroes context and base
    rst = 1; @(negedge clk); rst = 0;
    lk_valid = 1; lk_vpn = 8'h20; @(negedge clk); idle_inputs();
    check_rsp("R1 reset empties", 1'b0, 12'h020, 1'b0);

    // R9: fill and lookup in the same cycle, lookup sees old state
    fill_valid = 1; fill_vpn = 8'h50; fill_ppn = 6'h03;
    lk_valid = 1; lk_vpn = 8'h50; @(negedge clk); idle_inputs();
    check_rsp("R9 fill same cycle", 1'b0, 12'h050, 1'b0);
    lk_valid = 1; lk_vpn = 8'h50; @(negedge clk); idle_inputs();
    check_rsp("R9 fill visible next", 1'b1, 12'h003, 1'b0);

    // R9 and R4: context write in the same cycle as a lookup
    ctx_wr = 1; ctx_wr_id = 4'd1; ctx_wr_base = 12'h100;
    lk_valid = 1; lk_vpn = 8'h50; @(negedge clk); idle_inputs();
    check_rsp("R9 old context used", 1'b1, 12'h003, 1'b0);
    lk_valid = 1; lk_vpn = 8'h50; @(negedge clk); idle_inputs();
    check_rsp("R4 new context", 1'b0, 12'h150, 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule